// File: doc/BRIEF.md
# SDLC Receive Frame CRC Checker

This block judges the integrity of each received bit-oriented frame. It sits after the flag detector and the zero-bit remover of a serial receiver. It takes the de-stuffed data bits one at a time, each with a valid strobe. Alongside them come a level that says the receiver is hunting for a flag, a pulse for every flag that is not a closing flag, and a pulse for the closing flag that ends a frame.

The running remainder uses the 16-bit polynomial x^16 + x^12 + x^5 + 1 and covers every bit between the opening and closing flags. Checking is always on and has no enable. The sender transmits its check word inverted, so an intact frame does not leave a zero remainder. It leaves the fixed value 0x1D0F. When the frame ends, the block compares its remainder against that constant and presents three things: the pass/fail result, the raw remainder, and a one-cycle result strobe. The error flag only has meaning in the cycle the strobe is high.

The register reloads its start value by itself whenever the receiver hunts and whenever a flag arrives, so frames need no per-frame reset. A control input chooses an all-ones or an all-zeros start value. A clear command reloads the start value at any moment.

A control FSM tracks the receiver with three states:
- HUNT: the receiver is searching for a flag. The register is held at its start value. Bits and frame ends are ignored.
- OPEN: a flag has been seen and no data bit has arrived yet.
- DATA: at least one data bit has been accumulated.

Its transitions are:
- any state to HUNT while `hunt` is high;
- HUNT to OPEN on a flag or a closing flag;
- OPEN to DATA on an accepted bit;
- DATA to OPEN on a flag or a closing flag, latching the result in the closing-flag case.

Top module: `sdlc_rx_crc_check`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `res_valid`, `crc_err` and `crc_rem` are all 0. The FSM starts in HUNT.
- R2: Each accepted bit advances the register most-significant bit first: feedback = reg[15] XOR bit, reg = (reg << 1) XOR (feedback ? 0x1021 : 0). A frame whose data is followed by the inverted check word, sent bit 15 first, reports `crc_rem` = 0x1D0F and `crc_err` = 0.
- R3: At a result, `crc_err` is 1 exactly when the remainder differs from 0x1D0F, and `crc_rem` shows the remainder computed over all bits accepted since the last preset.
- R4: A preset loads 0xFFFF when `preset_ones` is 1 and 0x0000 when it is 0, using the value of `preset_ones` in that cycle.
- R5: While `hunt` is high, and afterwards until a flag or a closing flag, bits are ignored, the register holds its preset value, and `frame_end` produces no result.
- R6: A `flag_seen` pulse presets the register, so bits received before it do not affect the next result.
- R7: A `crc_clear` pulse presets the register without changing the FSM state.
- R8: On the clock edge that samples `frame_end` in DATA with `hunt` low, the block updates `crc_err` and `crc_rem` and raises `res_valid` for one cycle. The outputs are visible after that edge and hold until the next result.
- R9: A cycle with `bit_valid` low leaves the register unchanged. A bit strobed in the same cycle as a flag, a closing flag, `hunt` or `crc_clear` is not accumulated.
- R10: A `frame_end` in OPEN (a closing flag with no data bits since the last flag) produces no result and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_ones | input | 1 | Start value select: 1 = all ones, 0 = all zeros |
| crc_clear | input | 1 | Software command pulse that reloads the start value |
| hunt | input | 1 | High while the receiver searches for a flag |
| flag_seen | input | 1 | Pulse for a received flag that is not a closing flag |
| frame_end | input | 1 | Pulse for the closing flag of a frame |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | De-stuffed data bit |
| res_valid | output | 1 | One-cycle strobe: a frame result is present |
| crc_err | output | 1 | Frame check failed; meaningful with `res_valid` |
| crc_rem | output | 16 | Remainder latched at the last frame end |

## Verification
The hardest situation to reach is the one where several preset sources collide with data. Examples are a bit strobed in the same cycle as a flag, a clear, or the end of hunt, and a closing flag arriving while the FSM is still in HUNT after `hunt` has dropped. The stimulus reaches these by driving all control pulses from one tick task that can raise any combination in a single cycle, and by placing those collisions between the garbage bits and the payload of a frame. A sweep over both start values, three frame lengths and every single-bit corruption of each frame covers the residue comparison.

// File: rtl/sdlc_crc_pkg.sv
package sdlc_crc_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_DATA = 2'd2
    } rx_state_t;

endpackage

// File: rtl/sdlc_crc_ctrl.sv
module sdlc_crc_ctrl
    import sdlc_crc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hunt,
    input  logic flag_seen,
    input  logic frame_end,
    input  logic bit_valid,
    input  logic crc_clear,
    output logic preset_req,
    output logic shift_en,
    output logic latch_en,
    output logic in_hunt,
    output logic in_data
);

    rx_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (hunt) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: if (flag_seen || frame_end) state_d = ST_OPEN;
                ST_OPEN: if (!(flag_seen || frame_end || crc_clear) && bit_valid) state_d = ST_DATA;
                ST_DATA: if (flag_seen || frame_end) state_d = ST_OPEN;
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    always_comb begin
        preset_req = 1'b0;
        shift_en   = 1'b0;
        latch_en   = 1'b0;
        in_hunt    = 1'b0;
        in_data    = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                in_hunt    = 1'b1;
                preset_req = 1'b1;
            end
            ST_OPEN: begin
                preset_req = hunt || flag_seen || frame_end || crc_clear;
                shift_en   = bit_valid && !preset_req;
            end
            ST_DATA: begin
                in_data    = 1'b1;
                preset_req = hunt || flag_seen || frame_end || crc_clear;
                shift_en   = bit_valid && !preset_req;
                latch_en   = frame_end && !hunt;
            end
            default: preset_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/sdlc_crc_shift.sv
module sdlc_crc_shift #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset_ones,
    input  logic         preset_req,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] crc_reg
);

    logic [W-1:0] preset_val;
    logic [W-1:0] stepped;
    logic         feedback;

    assign preset_val = preset_ones ? {W{1'b1}} : {W{1'b0}};
    assign feedback   = crc_reg[W-1] ^ bit_in;
    assign stepped    = {crc_reg[W-2:0], 1'b0} ^ (feedback ? POLY : {W{1'b0}});

    always_ff @(posedge clk) begin
        if (rst || preset_req) crc_reg <= preset_val;
        else if (shift_en)     crc_reg <= stepped;
    end

endmodule

// File: rtl/sdlc_crc_judge.sv
module sdlc_crc_judge #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RESIDUE = 16'h1D0F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         latch_en,
    input  logic [W-1:0] crc_reg,
    output logic         res_valid,
    output logic         crc_err,
    output logic [W-1:0] crc_rem
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            crc_err   <= 1'b0;
            crc_rem   <= '0;
        end else begin
            res_valid <= latch_en;
            if (latch_en) begin
                crc_rem <= crc_reg;
                crc_err <= (crc_reg != RESIDUE);
            end
        end
    end

endmodule

// File: rtl/sdlc_rx_crc_check.sv
module sdlc_rx_crc_check #(
    parameter int           W       = 16,
    parameter logic [W-1:0] POLY    = 16'h1021,
    parameter logic [W-1:0] RESIDUE = 16'h1D0F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset_ones,
    input  logic         crc_clear,
    input  logic         hunt,
    input  logic         flag_seen,
    input  logic         frame_end,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         res_valid,
    output logic         crc_err,
    output logic [W-1:0] crc_rem
);

    logic         preset_req, shift_en, latch_en, in_hunt, in_data;
    logic [W-1:0] crc_reg;

    sdlc_crc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hunt       (hunt),
        .flag_seen  (flag_seen),
        .frame_end  (frame_end),
        .bit_valid  (bit_valid),
        .crc_clear  (crc_clear),
        .preset_req (preset_req),
        .shift_en   (shift_en),
        .latch_en   (latch_en),
        .in_hunt    (in_hunt),
        .in_data    (in_data)
    );

    sdlc_crc_shift #(.W(W), .POLY(POLY)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .preset_ones (preset_ones),
        .preset_req  (preset_req),
        .shift_en    (shift_en),
        .bit_in      (bit_in),
        .crc_reg     (crc_reg)
    );

    sdlc_crc_judge #(.W(W), .RESIDUE(RESIDUE)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .latch_en  (latch_en),
        .crc_reg   (crc_reg),
        .res_valid (res_valid),
        .crc_err   (crc_err),
        .crc_rem   (crc_rem)
    );

endmodule

// File: rtl/sdlc_rx_crc_props.sv
module sdlc_rx_crc_props #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RESIDUE = 16'h1D0F
) (
    input logic         clk,
    input logic         rst,
    input logic         preset_ones,
    input logic         crc_clear,
    input logic         hunt,
    input logic         flag_seen,
    input logic         frame_end,
    input logic         bit_valid,
    input logic         res_valid,
    input logic         crc_err,
    input logic [W-1:0] crc_rem,
    input logic [W-1:0] crc_reg,
    input logic         in_hunt,
    input logic         in_data
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && !crc_err && crc_rem == '0));

    assert_err_matches_rem_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (crc_err == (crc_rem != RESIDUE)));

    assert_hunt_preset_R5: assert property (@(posedge clk) disable iff (rst)
        hunt |=> (crc_reg == ($past(preset_ones) ? {W{1'b1}} : {W{1'b0}})));

    assert_hunt_no_result_R5: assert property (@(posedge clk) disable iff (rst)
        (hunt || in_hunt) |=> !res_valid);

    assert_flag_preset_R6: assert property (@(posedge clk) disable iff (rst)
        flag_seen |=> (crc_reg == ($past(preset_ones) ? {W{1'b1}} : {W{1'b0}})));

    assert_clear_preset_R7: assert property (@(posedge clk) disable iff (rst)
        crc_clear |=> (crc_reg == ($past(preset_ones) ? {W{1'b1}} : {W{1'b0}})));

    assert_result_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !hunt && in_data) |=> res_valid);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(crc_rem) && $stable(crc_err)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !hunt && !flag_seen && !frame_end && !crc_clear && !in_hunt) |=> $stable(crc_reg));

    assert_empty_frame_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !in_data) |=> !res_valid);

endmodule

bind sdlc_rx_crc_check sdlc_rx_crc_props #(.W(W), .RESIDUE(RESIDUE)) u_props (
    .clk         (clk),
    .rst         (rst),
    .preset_ones (preset_ones),
    .crc_clear   (crc_clear),
    .hunt        (hunt),
    .flag_seen   (flag_seen),
    .frame_end   (frame_end),
    .bit_valid   (bit_valid),
    .res_valid   (res_valid),
    .crc_err     (crc_err),
    .crc_rem     (crc_rem),
    .crc_reg     (crc_reg),
    .in_hunt     (in_hunt),
    .in_data     (in_data)
);

// File: tb/sdlc_rx_crc_check_bench.sv
module sdlc_rx_crc_check_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, preset_ones, crc_clear, hunt, flag_seen, frame_end, bit_valid, bit_in;
    logic        res_valid, crc_err;
    logic [15:0] crc_rem;

    int checks = 0;
    int fails  = 0;
    logic fbits [0:63];
    int   nbits;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdlc_rx_crc_check u_sdlc_rx_crc_check (
        .clk(clk), .rst(rst), .preset_ones(preset_ones), .crc_clear(crc_clear),
        .hunt(hunt), .flag_seen(flag_seen), .frame_end(frame_end),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .res_valid(res_valid), .crc_err(crc_err), .crc_rem(crc_rem)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v, input logic b, input logic fl, input logic fe,
                        input logic h, input logic cl);
        bit_valid = v; bit_in = b; flag_seen = fl; frame_end = fe; hunt = h; crc_clear = cl;
        @(negedge clk);
        bit_valid = 0; bit_in = 0; flag_seen = 0; frame_end = 0; hunt = 0; crc_clear = 0;
    endtask

    function automatic logic [15:0] model(input logic [15:0] init, input int n);
        logic [15:0] r = init;
        for (int i = 0; i < n; i++) begin
            logic fb = r[15] ^ fbits[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic build_frame(input int nbytes, input int seed, input logic [15:0] init);
        logic [15:0] c;
        nbits = nbytes * 8;
        for (int i = 0; i < nbits; i++) fbits[i] = ((seed * 7 + i * 5 + (i * i) % 11) % 3) == 0;
        c = ~model(init, nbits);
        for (int i = 0; i < 16; i++) fbits[nbits + i] = c[15 - i];
        nbits += 16;
    endtask

    task automatic send_frame(input string req, input logic gaps);
        logic [15:0] exp;
        exp = model(preset_ones ? 16'hFFFF : 16'h0000, nbits);
        tick(0, 0, 1, 0, 0, 0);
        for (int i = 0; i < nbits; i++) begin
            tick(1, fbits[i], 0, 0, 0, 0);
            if (gaps && (i % 3 == 0)) tick(0, ~fbits[i], 0, 0, 0, 0);
        end
        tick(0, 0, 0, 1, 0, 0);
        chk(res_valid == 1'b1, req, {31'd0, res_valid}, 32'd1);
        chk(crc_rem == exp, req, {16'd0, crc_rem}, {16'd0, exp});
        chk(crc_err == (exp != 16'h1D0F), req, {31'd0, crc_err}, {31'd0, exp != 16'h1D0F});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        rst = 1; preset_ones = 1; crc_clear = 0; hunt = 0; flag_seen = 0;
        frame_end = 0; bit_valid = 0; bit_in = 0;
        @(negedge clk); @(negedge clk);
        chk(res_valid == 0 && crc_err == 0 && crc_rem == 0, "R1", {crc_rem, 14'd0, crc_err, res_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk(res_valid == 0 && crc_err == 0 && crc_rem == 0, "R1", {crc_rem, 14'd0, crc_err, res_valid}, 32'd0);

        // R2 / R3 / R4: sweep start values, lengths and every single-bit corruption
        for (int p = 0; p < 2; p++) begin
            preset_ones = p[0];
            for (int len = 1; len <= 3; len++) begin
                build_frame(len, len + p * 3, preset_ones ? 16'hFFFF : 16'h0000);
                send_frame("R2", 0);
                chk(crc_rem == 16'h1D0F && crc_err == 0, "R2", {16'd0, crc_rem}, 32'h1D0F);
                for (int j = 0; j < nbits; j++) begin
                    fbits[j] = ~fbits[j];
                    send_frame("R3", 0);
                    chk(crc_err == 1'b1, "R3", {31'd0, crc_err}, 32'd1);
                    fbits[j] = ~fbits[j];
                end
            end
        end

        // R8 hold after result; R9 idle gaps
        preset_ones = 1;
        build_frame(2, 9, 16'hFFFF);
        send_frame("R9", 1);
        held = crc_rem;
        tick(0, 0, 0, 0, 0, 0);
        chk(res_valid == 0, "R8", {31'd0, res_valid}, 32'd0);
        chk(crc_rem == held, "R8", {16'd0, crc_rem}, {16'd0, held});

        // R4 / R7: clear in DATA then frame end shows the start value
        for (int p = 0; p < 2; p++) begin
            preset_ones = p[0];
            tick(0, 0, 1, 0, 0, 0);
            tick(1, 1, 0, 0, 0, 0);
            tick(1, 0, 0, 0, 0, 0);
            tick(1, 1, 0, 0, 0, 1);
            tick(0, 0, 0, 1, 0, 0);
            chk(res_valid == 1, "R7", {31'd0, res_valid}, 32'd1);
            chk(crc_rem == (p ? 16'hFFFF : 16'h0000), "R4", {16'd0, crc_rem}, p ? 32'hFFFF : 32'h0);
            chk(crc_err == 1, "R4", {31'd0, crc_err}, 32'd1);
        end

        // R5: hunt discards, frame_end ignored during and after hunt until a flag
        preset_ones = 1;
        held = crc_rem;
        tick(0, 0, 1, 0, 0, 0);
        tick(1, 1, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 1, 0);
        tick(1, 0, 0, 1, 1, 0);
        chk(res_valid == 0, "R5", {31'd0, res_valid}, 32'd0);
        tick(1, 1, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 0, 0);
        chk(res_valid == 0 && crc_rem == held, "R5", {15'd0, res_valid, crc_rem}, {16'd0, held});
        build_frame(1, 4, 16'hFFFF);
        send_frame("R5", 0);
        chk(crc_err == 0, "R5", {31'd0, crc_err}, 32'd0);

        // R6 / R9: garbage then a flag with a strobed bit, then a good frame
        preset_ones = 0;
        tick(1, 1, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0, 0);
        tick(1, 1, 0, 0, 0, 0);
        tick(1, 1, 1, 0, 0, 0);
        build_frame(2, 5, 16'h0000);
        for (int i = 0; i < nbits; i++) tick(1, fbits[i], 0, 0, 0, 0);
        tick(1, 1, 0, 1, 0, 0);
        chk(res_valid == 1 && crc_rem == 16'h1D0F, "R6", {15'd0, res_valid, crc_rem}, 32'h11D0F);
        chk(crc_err == 0, "R9", {31'd0, crc_err}, 32'd0);

        // R10: empty frame between flags
        held = crc_rem;
        tick(0, 0, 1, 0, 0, 0);
        tick(0, 0, 0, 1, 0, 0);
        chk(res_valid == 0 && crc_rem == held, "R10", {15'd0, res_valid, crc_rem}, {16'd0, held});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule